// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block carries a stream of data words from a write clock domain to a read clock domain when the two clocks have no fixed relationship. Each side counts its position in binary. Each side also keeps a registered Gray-coded copy of that count, which is the only value that crosses to the other domain. A synchroniser chain on each crossing re-times the incoming Gray pointer. The write side derives its full flag from the synchronised read pointer, and the read side derives its empty flag from the synchronised write pointer.

The Gray register is loaded from the same next-state value that feeds the binary counter. The two registers therefore always hold the same count, and the Gray lines never glitch. On the read side, the synchronised write pointer is decoded back to binary. This gives a fill count, which is compared with a level input to raise an almost-empty warning.

With the default parameters the storage holds 32 words of 8 bits, and the pointers are 6 bits wide. Read data is registered: a word appears on the output one read-clock edge after its read is accepted.

Top module: `async_gray_fifo`

## Requirements
- R1: Words leave in the order they were accepted, with no loss and no duplication, and the FIFO can hold 2^ADDR_W words (32 by default) at once.
- R2: Once writes stop and a few read-clock and write-clock cycles have passed, `full` is 1 exactly when 2^ADDR_W words are stored. A write request while `full` is 1 is ignored and changes neither the stored words nor the write pointer.
- R3: Once activity stops and the flags have settled, `empty` is 1 exactly when no word is stored. A read request while `empty` is 1 is ignored: `rd_data` keeps its value and the read pointer does not move.
- R4: After settling, `almost_empty` is 1 exactly when the read-side fill count is less than or equal to `ae_level`, an unsigned value of ADDR_W+1 bits. The flag follows a change of `ae_level` within two read-clock cycles.
- R5: Each Gray pointer register changes in at most one bit per clock of its domain. It always encodes the same count as the binary pointer of the same side, with gray = bin XOR (bin >> 1).
- R6: While its reset is low, each domain holds `full` = 0, `empty` = 1, `almost_empty` = 1 and `rd_data` = 0.
- R7: An accepted read (`rd_en` = 1 while `empty` = 0 at a rising `rclk` edge) presents the oldest word on `rd_data` after that same edge, and the read pointer advances by one.
- R8: Under simultaneous, irregular traffic on both sides, a write is never accepted with 2^ADDR_W words stored, and a read is never accepted with none stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-domain clock |
| wrst_n | input | 1 | Write-domain reset, active low, asynchronous assert |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free entry as seen by the write side |
| rclk | input | 1 | Read-domain clock |
| rrst_n | input | 1 | Read-domain reset, active low, asynchronous assert |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered output word |
| empty | output | 1 | No stored word as seen by the read side |
| ae_level | input | ADDR_W+1 | Almost-empty threshold in words |
| almost_empty | output | 1 | Fill count at or below `ae_level` |

## Verification
A corrupted binary pointer on either side shows up at `rd_data` as the wrong word, or as a stale or repeated word, at the first read that reaches the affected entry. A read pointer that disagrees with its Gray copy appears as a flag that never settles to the true fill level. The bench checks this a dozen cycles after each burst stops. A wrongly accepted write while full overwrites the oldest unread word, and the next drain exposes it. A read wrongly accepted while empty changes `rd_data` on the very next read-clock edge.

// File: rtl/afifo_pkg.sv
`timescale 1ns/1ps
package afifo_pkg;

    typedef logic [31:0] ptr_word_t;

    function automatic ptr_word_t to_gray(ptr_word_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_word_t from_gray(ptr_word_t g);
        ptr_word_t b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/afifo_sync.sv
`timescale 1ns/1ps
module afifo_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] q;
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= g_stage[g-1].q;
            end
        end
    end

    assign dout = g_stage[STAGES-1].q;

endmodule

// File: rtl/afifo_wr_ctl.sv
`timescale 1ns/1ps
module afifo_wr_ctl
    import afifo_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output logic              full,
    output logic              wr_fire
);

    localparam int PW = ADDR_W + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full;
    } wstate_t;

    localparam wstate_t W_RESET = '{bin: '0, gray: '0, full: 1'b0};

    wstate_t s_d, s_q;
    logic [PW-1:0] full_pattern;

    always_comb begin
        s_d          = s_q;
        wr_fire      = wr_en && !s_q.full;
        s_d.bin      = s_q.bin + PW'(wr_fire);
        s_d.gray     = PW'(to_gray(ptr_word_t'(s_d.bin)));
        full_pattern = {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]};
        s_d.full     = (s_d.gray == full_pattern);
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) s_q <= W_RESET;
        else         s_q <= s_d;
    end

    assign waddr = s_q.bin[ADDR_W-1:0];
    assign wgray = s_q.gray;
    assign full  = s_q.full;

    AST_WR_HOLD_WHEN_FULL: assert property (@(posedge wclk) disable iff (!wrst_n)
        (wr_en && s_q.full) |=> (s_q.bin == $past(s_q.bin))); // R2
    AST_WR_ADVANCE: assert property (@(posedge wclk) disable iff (!wrst_n)
        (wr_en && !s_q.full) |=> (s_q.bin == $past(s_q.bin) + PW'(1))); // R1
    AST_WR_GRAY_STEP: assert property (@(posedge wclk) disable iff (!wrst_n)
        $countones(s_q.gray ^ $past(s_q.gray)) <= 1); // R5
    AST_WR_GRAY_TRACKS_BIN: assert property (@(posedge wclk) disable iff (!wrst_n)
        from_gray(ptr_word_t'(s_q.gray)) == ptr_word_t'(s_q.bin)); // R5

endmodule

// File: rtl/afifo_rd_ctl.sv
`timescale 1ns/1ps
module afifo_rd_ctl
    import afifo_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wgray_sync,
    input  logic [ADDR_W:0]   ae_level,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic              empty,
    output logic              almost_empty,
    output logic              rd_fire
);

    localparam int PW = ADDR_W + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          empty;
        logic          aempty;
    } rstate_t;

    localparam rstate_t R_RESET = '{bin: '0, gray: '0, empty: 1'b1, aempty: 1'b1};

    rstate_t s_d, s_q;
    logic [PW-1:0] wbin_seen;
    logic [PW-1:0] fill_d;

    always_comb begin
        s_d        = s_q;
        rd_fire    = rd_en && !s_q.empty;
        s_d.bin    = s_q.bin + PW'(rd_fire);
        s_d.gray   = PW'(to_gray(ptr_word_t'(s_d.bin)));
        s_d.empty  = (s_d.gray == wgray_sync);
        wbin_seen  = PW'(from_gray(ptr_word_t'(wgray_sync)));
        fill_d     = wbin_seen - s_d.bin;
        s_d.aempty = (fill_d <= ae_level);
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) s_q <= R_RESET;
        else         s_q <= s_d;
    end

    assign raddr        = s_q.bin[ADDR_W-1:0];
    assign rgray        = s_q.gray;
    assign empty        = s_q.empty;
    assign almost_empty = s_q.aempty;

    AST_RD_HOLD_WHEN_EMPTY: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rd_en && s_q.empty) |=> (s_q.bin == $past(s_q.bin))); // R3
    AST_RD_ADVANCE: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rd_en && !s_q.empty) |=> (s_q.bin == $past(s_q.bin) + PW'(1))); // R7
    AST_RD_GRAY_STEP: assert property (@(posedge rclk) disable iff (!rrst_n)
        $countones(s_q.gray ^ $past(s_q.gray)) <= 1); // R5
    AST_AE_COVERS_EMPTY: assert property (@(posedge rclk) disable iff (!rrst_n)
        s_q.empty |-> s_q.aempty); // R4

endmodule

// File: rtl/afifo_store.sv
`timescale 1ns/1ps
module afifo_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    always_comb begin
        rdata_d = rdata_q;
        if (re) rdata_d = cells[raddr];
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) rdata_q <= '0;
        else         rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    AST_RDATA_HELD_IDLE: assert property (@(posedge rclk) disable iff (!rrst_n)
        !re |=> $stable(rdata_q)); // R3

endmodule

// File: rtl/async_gray_fifo.sv
`timescale 1ns/1ps
module async_gray_fifo #(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    input  logic [ADDR_W:0]   ae_level,
    output logic              almost_empty
);

    localparam int PW = ADDR_W + 1;

    logic [ADDR_W-1:0] waddr, raddr;
    logic [PW-1:0]     wgray, rgray, wgray_rs, rgray_ws;
    logic              wr_fire, rd_fire;

    afifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
        .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .rgray_sync(rgray_ws),
        .waddr(waddr), .wgray(wgray), .full(full), .wr_fire(wr_fire)
    );

    afifo_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
        .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .wgray_sync(wgray_rs),
        .ae_level(ae_level), .raddr(raddr), .rgray(rgray), .empty(empty),
        .almost_empty(almost_empty), .rd_fire(rd_fire)
    );

    afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
        .clk(rclk), .rst_n(rrst_n), .din(wgray), .dout(wgray_rs)
    );

    afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
        .clk(wclk), .rst_n(wrst_n), .din(rgray), .dout(rgray_ws)
    );

    afifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
        .rclk(rclk), .rrst_n(rrst_n), .re(rd_fire), .raddr(raddr), .rdata(rd_data)
    );

endmodule

// File: tb/tb_async_gray_fifo.sv
`timescale 1ns/1ps
module tb_async_gray_fifo;

    localparam int DW  = 8;
    localparam int AW  = 5;
    localparam int CAP = 1 << AW;

    logic wclk = 1'b0, rclk = 1'b0;
    logic wrst_n = 1'b0, rrst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [AW:0] ae_level = 6'd4;
    logic full, empty, almost_empty;
    logic [DW-1:0] rd_data;

    int checks = 0, errors = 0;
    int model_q[$];
    bit wr_act = 0, rd_act = 0;
    int wr_pct = 100, rd_pct = 100;
    logic [DW-1:0] next_val = 8'h01;
    bit pend = 0, ign = 0;
    int pend_v = 0;
    logic [DW-1:0] held = '0;

    always #2 wclk = ~wclk;
    initial begin
        #1.3;
        forever #3 rclk = ~rclk;
    end

    async_gray_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) dut (
        .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
        .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_data(rd_data), .empty(empty),
        .ae_level(ae_level), .almost_empty(almost_empty)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // write-side driver and model
    initial forever begin
        @(negedge wclk);
        if (wrst_n && wr_act && int'($urandom_range(99)) < wr_pct) begin
            wr_en = 1'b1;
            if (!full) begin
                wr_data = next_val;
                check(model_q.size() < CAP, "R8 write accepted with all entries used", model_q.size(), CAP - 1);
                model_q.push_back(int'(next_val));
                next_val = next_val + 8'd1;
            end else begin
                wr_data = ~next_val;   // R2: must not land in the array
            end
        end else begin
            wr_en = 1'b0;
        end
    end

    // read-side driver and model
    initial forever begin
        @(negedge rclk);
        if (pend) begin
            check(int'(rd_data) == pend_v, "R1 R7 read word order", int'(rd_data), pend_v);
            pend = 0;
        end
        if (ign) begin
            check(rd_data === held, "R3 ignored read kept rd_data", int'(rd_data), int'(held));
            ign = 0;
        end
        if (rrst_n && rd_act && int'($urandom_range(99)) < rd_pct) begin
            rd_en = 1'b1;
            if (!empty) begin
                check(model_q.size() > 0, "R8 read accepted with nothing stored", model_q.size(), 1);
                if (model_q.size() > 0) begin
                    pend_v = model_q.pop_front();
                    pend = 1;
                end
            end else begin
                ign = 1;
                held = rd_data;
            end
        end else begin
            rd_en = 1'b0;
        end
    end

    task automatic settle_check(string tag);
        int n;
        wr_act = 0;
        rd_act = 0;
        repeat (12) @(negedge rclk);
        repeat (4) @(negedge wclk);
        n = model_q.size();
        check(full == (n == CAP), {"R2 full after ", tag}, int'(full), int'(n == CAP));
        @(negedge rclk);
        check(empty == (n == 0), {"R3 empty after ", tag}, int'(empty), int'(n == 0));
        check(almost_empty == (n <= int'(ae_level)), {"R4 almost_empty after ", tag},
              int'(almost_empty), int'(n <= int'(ae_level)));
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_up();
    end

    initial begin
        #10;
        // R6: reset values
        check(full == 1'b0, "R6 full in reset", int'(full), 0);
        check(empty == 1'b1, "R6 empty in reset", int'(empty), 1);
        check(almost_empty == 1'b1, "R6 almost_empty in reset", int'(almost_empty), 1);
        check(rd_data == '0, "R6 rd_data in reset", int'(rd_data), 0);
        @(negedge wclk); wrst_n = 1'b1;
        @(negedge rclk); rrst_n = 1'b1;
        repeat (4) @(negedge rclk);

        // R3: reads on an empty FIFO are ignored
        rd_act = 1; rd_pct = 100;
        repeat (6) @(negedge rclk);
        settle_check("idle reads");

        // partial fill to 10 words
        wr_act = 1; wr_pct = 100;
        while (model_q.size() < 10) @(posedge wclk);
        wr_act = 0;
        settle_check("ten writes");
        // R4: threshold boundary on a level change
        ae_level = 6'd10;
        repeat (3) @(negedge rclk);
        check(almost_empty == 1'b1, "R4 level equal to fill", int'(almost_empty), 1);
        ae_level = 6'd9;
        repeat (3) @(negedge rclk);
        check(almost_empty == 1'b0, "R4 level one below fill", int'(almost_empty), 0);

        // R1 R2: fill to capacity and keep pushing
        wr_act = 1; wr_pct = 100;
        repeat (70) @(posedge wclk);
        settle_check("overfill");
        check(model_q.size() == CAP, "R1 capacity", model_q.size(), CAP);
        ae_level = 6'd31;
        repeat (3) @(negedge rclk);
        check(almost_empty == 1'b0, "R4 full FIFO above level", int'(almost_empty), 0);
        ae_level = 6'd32;
        repeat (3) @(negedge rclk);
        check(almost_empty == 1'b1, "R4 full FIFO at level", int'(almost_empty), 1);
        ae_level = 6'd4;

        // drain past empty
        rd_act = 1; rd_pct = 100;
        repeat (90) @(posedge rclk);
        settle_check("drain");

        // R8: irregular concurrent traffic
        for (int k = 0; k < 4; k++) begin
            case (k)
                0: begin wr_pct = 50; rd_pct = 50; end
                1: begin wr_pct = 90; rd_pct = 30; end
                2: begin wr_pct = 30; rd_pct = 90; end
                default: begin wr_pct = 75; rd_pct = 70; end
            endcase
            ae_level = 6'(3 + 5 * k);
            wr_act = 1; rd_act = 1;
            repeat (2500) @(posedge wclk);
            settle_check("mixed traffic");
        end
        rd_act = 1; rd_pct = 100;
        repeat (100) @(posedge rclk);
        settle_check("final drain");
        check(model_q.size() == 0, "R1 all words returned", model_q.size(), 0);
        finish_up();
    end

endmodule